// File: doc/BRIEF.md
# Fixed-Point Fractional Multiply Unit

This block is a lane-level datapath that multiplies pairs of signed fixed-point fractions. Each lane takes two operands of a run-time selectable element width (8, 16 or 32 bits), forms their full-precision signed product, and scales it back to the element width by an arithmetic right shift of one less than the width. The bits shifted out are rounded under one of four selectable rules. If the rounded value does not fit the signed element range, it is clamped to the nearest signed extreme and a sticky saturation flag is raised.

Several lanes run side by side, and a new group of elements can enter on every clock. A per-lane enable, gated by a global mask switch, lets an element pass its old destination value through unchanged. The result appears a fixed two cycles after the input strobe. The saturation flag accumulates across lanes and cycles until it is cleared by a pulse on a dedicated input.

Top module: `fxm_lanes`

## Requirements
- R1: While reset is held (synchronous, active high) and on the first sample after it, out_valid, sat_flag and every result bit are 0.
- R2: A group presented with in_valid high at a rising edge appears on result with out_valid high exactly two rising edges later. Groups may be presented on consecutive cycles. out_valid is low two edges after an edge where in_valid was low.
- R3: width_sel selects the element width: 00 = 8 bits, 01 = 16 bits, 10 or 11 = 32 bits. Only the low width bits of each 32-bit operand slice are used, taken as two's complement. An active lane's 32-bit result slice is the width-bit result sign-extended.
- R4: The kept value is the full signed product shifted arithmetically right by width-1. Rounding code 10 truncates toward minus infinity, so nothing is added.
- R5: Rounding code 00 adds the most significant discarded bit to the kept value.
- R6: Rounding code 01 rounds to nearest, and an exact half rounds so that the kept LSB becomes 0.
- R7: Rounding code 11 sets the kept LSB to 1 when it is 0 and any discarded bit is 1.
- R8: When both operands equal the most negative value of the width, the result is the most positive value and sat_flag becomes 1 with that result.
- R9: sat_flag stays 1 until a sat_clr pulse is sampled. A saturation that reaches the output at the same edge as a clear wins, and the flag remains 1.
- R10: When mask_on is 1, a lane whose lane_en bit is 0 outputs its old_dst slice unchanged and cannot set sat_flag. When mask_on is 0, all lanes are active whatever lane_en holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input group strobe |
| mask_on | input | 1 | Enables per-lane masking by lane_en |
| lane_en | input | LANES | Per-lane element enable (used when mask_on is 1) |
| width_sel | input | 2 | Element width code |
| rnd_mode | input | 2 | Rounding rule code |
| op_a | input | LANES*MAX_W | First operand per lane |
| op_b | input | LANES*MAX_W | Second operand per lane |
| old_dst | input | LANES*MAX_W | Value kept by masked-off lanes |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result group strobe |
| result | output | LANES*MAX_W | Result per lane |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
A wrong product, width or rounding code held in the first pipeline stage shows as a wrong result slice exactly two edges after the group enters. A lost or duplicated strobe shows as out_valid at the wrong cycle. A sticky flag that clears itself, ignores a clear, or is raised by a masked lane differs from the model at the first sample after the edge in question. The bench compares every lane, the strobe and the flag against a behavioural model on every cycle, so any such divergence is caught in the cycle it reaches the ports.

// File: rtl/fxm_pkg.sv
package fxm_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_UP  = 2'b00,
    RND_NEAR_EVN = 2'b01,
    RND_DOWN     = 2'b10,
    RND_ODD      = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    EW_8   = 2'b00,
    EW_16  = 2'b01,
    EW_32  = 2'b10,
    EW_32B = 2'b11
  } elem_w_e;

  // Element width in bits for a width code; both upper codes mean 32.
  function automatic int unsigned width_bits(input logic [1:0] code);
    case (elem_w_e'(code))
      EW_8:    return 8;
      EW_16:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/fxm_sext_mul.sv
module fxm_sext_mul
  import fxm_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input  logic [MAX_W-1:0]          a,
  input  logic [MAX_W-1:0]          b,
  input  logic [1:0]                wsel,
  output logic signed [2*MAX_W-1:0] prod
);
  localparam int PROD_W = 2 * MAX_W;

  logic signed [MAX_W-1:0]  a_s, b_s;
  logic signed [PROD_W-1:0] a_x, b_x;
  int unsigned              pad;

  always_comb begin
    pad  = MAX_W - width_bits(wsel);
    // move the element's sign bit to the top, then shift back arithmetically
    a_s  = $signed(a << pad) >>> pad;
    b_s  = $signed(b << pad) >>> pad;
    a_x  = PROD_W'(a_s);
    b_x  = PROD_W'(b_s);
    prod = a_x * b_x;
  end

endmodule

// File: rtl/fxm_round_sat.sv
module fxm_round_sat
  import fxm_pkg::*;
#(
  parameter int MAX_W = 32
) (
  input  logic signed [2*MAX_W-1:0] prod,
  input  logic [1:0]                wsel,
  input  logic [1:0]                rmode,
  output logic [MAX_W-1:0]          res,
  output logic                      sat
);
  localparam int PROD_W = 2 * MAX_W;
  localparam logic [PROD_W-1:0] ONE = PROD_W'(1);

  logic signed [PROD_W-1:0] kept, rnd_val, max_v, min_v;
  logic                     guard, tail, inc;
  int unsigned              shamt;

  always_comb begin
    shamt = width_bits(wsel) - 1;
    kept  = prod >>> shamt;
    guard = |(prod & (ONE << (shamt - 1)));
    tail  = |(prod & ((ONE << (shamt - 1)) - ONE));
    case (rnd_mode_e'(rmode))
      RND_NEAR_UP:  inc = guard;
      RND_NEAR_EVN: inc = guard & (tail | kept[0]);
      RND_DOWN:     inc = 1'b0;
      default:      inc = ~kept[0] & (guard | tail);
    endcase
    rnd_val = kept + $signed({{(PROD_W-1){1'b0}}, inc});
    max_v   = $signed((ONE << shamt) - ONE);
    min_v   = ~max_v;
    if (rnd_val > max_v) begin
      sat = 1'b1;
      res = max_v[MAX_W-1:0];
    end else if (rnd_val < min_v) begin
      sat = 1'b1;
      res = min_v[MAX_W-1:0];
    end else begin
      sat = 1'b0;
      res = rnd_val[MAX_W-1:0];
    end
  end

endmodule

// File: rtl/fxm_sat_sticky.sv
module fxm_sat_sticky (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic set,
  output logic flag
);
  // a new event at the same edge as a clear leaves the flag set
  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= (flag & ~clr) | set;
  end
endmodule

// File: rtl/fxm_lanes.sv
module fxm_lanes
  import fxm_pkg::*;
#(
  parameter int LANES = 2,
  parameter int MAX_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic                   mask_on,
  input  logic [LANES-1:0]       lane_en,
  input  logic [1:0]             width_sel,
  input  logic [1:0]             rnd_mode,
  input  logic [LANES*MAX_W-1:0] op_a,
  input  logic [LANES*MAX_W-1:0] op_b,
  input  logic [LANES*MAX_W-1:0] old_dst,
  input  logic                   sat_clr,
  output logic                   out_valid,
  output logic [LANES*MAX_W-1:0] result,
  output logic                   sat_flag
);
  localparam int PROD_W = 2 * MAX_W;
  localparam int BUS_W  = LANES * MAX_W;

  logic [LANES-1:0]         act_in;
  logic signed [PROD_W-1:0] prod_c  [LANES];

  logic                     s1_vld;
  logic [LANES-1:0]         s1_act;
  logic signed [PROD_W-1:0] s1_prod [LANES];
  logic [BUS_W-1:0]         s1_old;
  logic [1:0]               s1_wsel;
  logic [1:0]               s1_rmode;

  logic [BUS_W-1:0]         res_c;
  logic [BUS_W-1:0]         merged_c;
  logic [LANES-1:0]         lane_sat;
  logic                     sat_set;

  assign act_in = mask_on ? lane_en : {LANES{1'b1}};

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      fxm_sext_mul #(.MAX_W(MAX_W)) u_mul (
        .a    (op_a[g*MAX_W +: MAX_W]),
        .b    (op_b[g*MAX_W +: MAX_W]),
        .wsel (width_sel),
        .prod (prod_c[g])
      );

      fxm_round_sat #(.MAX_W(MAX_W)) u_rs (
        .prod  (s1_prod[g]),
        .wsel  (s1_wsel),
        .rmode (s1_rmode),
        .res   (res_c[g*MAX_W +: MAX_W]),
        .sat   (lane_sat[g])
      );

      assign merged_c[g*MAX_W +: MAX_W] = s1_act[g] ? res_c[g*MAX_W +: MAX_W]
                                                    : s1_old[g*MAX_W +: MAX_W];
    end
  endgenerate

  // stage 1: full products and control
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
      s1_act <= '0;
    end else begin
      s1_vld <= in_valid;
      if (in_valid) begin
        s1_act   <= act_in;
        s1_prod  <= prod_c;
        s1_old   <= old_dst;
        s1_wsel  <= width_sel;
        s1_rmode <= rnd_mode;
      end
    end
  end

  // stage 2: scaled, rounded, clamped results
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= s1_vld;
      if (s1_vld) result <= merged_c;
    end
  end

  assign sat_set = s1_vld & |(lane_sat & s1_act);

  fxm_sat_sticky u_sticky (
    .clk  (clk),
    .rst  (rst),
    .clr  (sat_clr),
    .set  (sat_set),
    .flag (sat_flag)
  );

endmodule

// File: rtl/fxm_lanes_chk.sv
module fxm_lanes_chk #(
  parameter int LANES = 2,
  parameter int MAX_W = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic                   sat_clr,
  input logic                   out_valid,
  input logic                   sat_flag,
  input logic                   s1_vld,
  input logic [LANES-1:0]       s1_act,
  input logic [LANES*MAX_W-1:0] s1_old,
  input logic [LANES*MAX_W-1:0] result
);

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (sat_flag && !sat_clr) |=> sat_flag);

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    sat_clr |=> (!sat_flag || out_valid));

  p_rise_with_data_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(sat_flag) |-> out_valid);

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_chk
      p_mask_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (s1_vld && !s1_act[g]) |=>
          (result[g*MAX_W +: MAX_W] == $past(s1_old[g*MAX_W +: MAX_W])));
    end
  endgenerate

endmodule

bind fxm_lanes fxm_lanes_chk #(.LANES(LANES), .MAX_W(MAX_W)) u_fxm_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .sat_clr   (sat_clr),
  .out_valid (out_valid),
  .sat_flag  (sat_flag),
  .s1_vld    (s1_vld),
  .s1_act    (s1_act),
  .s1_old    (s1_old),
  .result    (result)
);

// File: tb/test_fxm_lanes.sv
`timescale 1ns/1ps
module test_fxm_lanes;
  localparam int LANES = 2;
  localparam int W     = 32;

  logic             clk = 1'b0;
  logic             rst;
  logic             in_valid, mask_on, sat_clr;
  logic [LANES-1:0] lane_en;
  logic [1:0]       width_sel, rnd_mode;
  logic [LANES*W-1:0] op_a, op_b, old_dst;
  logic             out_valid, sat_flag;
  logic [LANES*W-1:0] result;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  fxm_lanes #(.LANES(LANES), .MAX_W(W)) i_fxm_lanes (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mask_on(mask_on),
    .lane_en(lane_en), .width_sel(width_sel), .rnd_mode(rnd_mode),
    .op_a(op_a), .op_b(op_b), .old_dst(old_dst), .sat_clr(sat_clr),
    .out_valid(out_valid), .result(result), .sat_flag(sat_flag)
  );

  typedef struct {
    bit          vld;
    logic [31:0] r0;
    logic [31:0] r1;
    bit          sat;
    bit          clr;
    string       tag;
  } ent_t;

  ent_t pipe0, pipe1;
  bit   exp_sat;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // behavioural reference: integer arithmetic on the real values
  task automatic ref_elem(input logic [31:0] a, input logic [31:0] b,
                          input logic [1:0] ws, input logic [1:0] rm,
                          output logic [31:0] r, output bit s);
    int     w;
    longint av, bv, p, kept, rem, half, lim;
    w  = (ws == 2'b00) ? 8 : (ws == 2'b01) ? 16 : 32;
    av = longint'({32'b0, a}) & ((longint'(1) << w) - 1);
    bv = longint'({32'b0, b}) & ((longint'(1) << w) - 1);
    if (av >= (longint'(1) << (w - 1))) av = av - (longint'(1) << w);
    if (bv >= (longint'(1) << (w - 1))) bv = bv - (longint'(1) << w);
    p    = av * bv;
    kept = p >>> (w - 1);
    rem  = p - (kept <<< (w - 1));
    half = longint'(1) << (w - 2);
    case (rm)
      2'b00: if (rem >= half) kept = kept + 1;
      2'b01: if (rem > half || (rem == half && kept[0])) kept = kept + 1;
      2'b10: ;
      default: if (rem != 0 && !kept[0]) kept = kept + 1;
    endcase
    lim = longint'(1) << (w - 1);
    s = 1'b0;
    if (kept > lim - 1) begin kept = lim - 1; s = 1'b1; end
    else if (kept < -lim) begin kept = -lim; s = 1'b1; end
    r = kept[31:0];
  endtask

  // one cycle: compare outputs, update model, drive next inputs
  task automatic step(input bit v, input bit mo, input logic [1:0] en,
                      input logic [1:0] ws, input logic [1:0] rm,
                      input logic [31:0] a0, input logic [31:0] b0,
                      input logic [31:0] a1, input logic [31:0] b1,
                      input logic [31:0] o0, input logic [31:0] o1,
                      input bit clr, input string tag);
    ent_t        e;
    logic [31:0] r0, r1;
    bit          s0, s1, act0, act1;
    check(out_valid === pipe1.vld, "R2", "out_valid", {31'b0, out_valid}, {31'b0, pipe1.vld});
    if (pipe1.vld) begin
      check(result[31:0] === pipe1.r0, pipe1.tag, "lane0", result[31:0], pipe1.r0);
      check(result[63:32] === pipe1.r1, pipe1.tag, "lane1", result[63:32], pipe1.r1);
    end
    exp_sat = (exp_sat && !pipe0.clr) || (pipe1.vld && pipe1.sat);
    check(sat_flag === exp_sat, pipe1.vld ? pipe1.tag : "R9", "sat_flag",
          {31'b0, sat_flag}, {31'b0, exp_sat});

    act0 = !mo || en[0];
    act1 = !mo || en[1];
    ref_elem(a0, b0, ws, rm, r0, s0);
    ref_elem(a1, b1, ws, rm, r1, s1);
    e.vld = v;
    e.r0  = act0 ? r0 : o0;
    e.r1  = act1 ? r1 : o1;
    e.sat = v && ((act0 && s0) || (act1 && s1));
    e.clr = clr;
    e.tag = tag;
    pipe1 = pipe0;
    pipe0 = e;

    in_valid  = v;
    mask_on   = mo;
    lane_en   = en;
    width_sel = ws;
    rnd_mode  = rm;
    op_a      = {a1, a0};
    op_b      = {b1, b0};
    old_dst   = {o1, o0};
    sat_clr   = clr;
    @(negedge clk);
  endtask

  task automatic idle(input bit clr);
    step(1'b0, 1'b0, 2'b11, 2'b10, 2'b10, 0, 0, 0, 0, 0, 0, clr, "R2");
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    pipe0 = '{vld: 0, r0: 0, r1: 0, sat: 0, clr: 0, tag: "R1"};
    pipe1 = pipe0;
    exp_sat = 1'b0;
    rst = 1'b1;
    in_valid = 0; mask_on = 0; lane_en = 0; width_sel = 0; rnd_mode = 0;
    op_a = 0; op_b = 0; old_dst = 0; sat_clr = 0;
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R1", "reset out_valid", {31'b0, out_valid}, 0);
    check(sat_flag === 1'b0, "R1", "reset sat_flag", {31'b0, sat_flag}, 0);
    check(result === '0, "R1", "reset result", result[31:0] | result[63:32], 0);
    rst = 1'b0;

    // R4: truncating scale, 32-bit
    step(1, 0, 2'b00, 2'b10, 2'b10, 32'h4000_0000, 32'h4000_0000,
         32'h6000_0000, 32'hC000_0000, 0, 0, 0, "R4");
    step(1, 0, 2'b00, 2'b10, 2'b10, 32'h7FFF_FFFF, 32'h7FFF_FFFF,
         32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 0, "R4");
    // R3: narrow widths, upper bits ignored, sign extension of result
    step(1, 0, 2'b00, 2'b00, 2'b10, 32'hABCD_1240, 32'h1234_5660,
         32'h0000_00FF, 32'hFFFF_FF80, 0, 0, 0, "R3");
    step(1, 0, 2'b00, 2'b01, 2'b00, 32'h5555_C000, 32'h0000_4000,
         32'hFFFF_8001, 32'h1111_7FFF, 0, 0, 0, "R3");
    step(1, 0, 2'b00, 2'b11, 2'b01, 32'h8000_0001, 32'h0000_0003,
         32'h1234_5678, 32'h9ABC_DEF0, 0, 0, 0, "R3");
    // exact halves and near-halves at 8 bits under each rounding rule
    for (int m = 0; m < 4; m++) begin
      string t;
      t = (m == 0) ? "R5" : (m == 1) ? "R6" : (m == 2) ? "R4" : "R7";
      step(1, 0, 2'b00, 2'b00, m[1:0], 32'h01, 32'h40, 32'h03, 32'h40, 0, 0, 0, t);
      step(1, 0, 2'b00, 2'b00, m[1:0], 32'hFF, 32'h40, 32'hFD, 32'h40, 0, 0, 0, t);
      step(1, 0, 2'b00, 2'b00, m[1:0], 32'h05, 32'h11, 32'h02, 32'h40, 0, 0, 0, t);
      step(1, 0, 2'b00, 2'b01, m[1:0], 32'h0003, 32'h4000, 32'hFFFB, 32'h2001, 0, 0, 0, t);
    end
    idle(1'b1);
    idle(1'b0);

    // R8: most negative squared at every width
    step(1, 0, 2'b00, 2'b00, 2'b00, 32'h80, 32'h80, 32'h10, 32'h20, 0, 0, 0, "R8");
    step(1, 0, 2'b00, 2'b01, 2'b01, 32'h8000, 32'h8000, 32'h0, 32'h0, 0, 0, 0, "R8");
    step(1, 0, 2'b00, 2'b10, 2'b11, 32'h1, 32'h1, 32'h8000_0000, 32'h8000_0000, 0, 0, 0, "R8");
    idle(1'b0);
    idle(1'b0);
    // R9: clear alone, then clear colliding with a new saturation
    idle(1'b1);
    idle(1'b0);
    idle(1'b0);
    step(1, 0, 2'b00, 2'b00, 2'b10, 32'h80, 32'h80, 0, 0, 0, 0, 0, "R9");
    idle(1'b1);
    idle(1'b0);
    idle(1'b0);
    idle(1'b1);
    idle(1'b0);

    // R10: masked lanes keep old value and cannot saturate
    step(1, 1, 2'b01, 2'b00, 2'b00, 32'h40, 32'h40, 32'h80, 32'h80,
         32'h1111_1111, 32'hDEAD_BEEF, 0, "R10");
    step(1, 1, 2'b10, 2'b10, 2'b00, 32'h8000_0000, 32'h8000_0000,
         32'h2000_0000, 32'h2000_0000, 32'hCAFE_F00D, 32'h0, 0, "R10");
    step(1, 1, 2'b00, 2'b01, 2'b01, 32'h8000, 32'h8000, 32'h8000, 32'h8000,
         32'h0000_00AA, 32'h0000_0055, 0, "R10");
    step(1, 0, 2'b00, 2'b00, 2'b10, 32'h60, 32'h60, 32'hA0, 32'h60,
         32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R10");
    idle(1'b0);
    idle(1'b0);

    // R2: dense stream with gaps, mixed widths, modes, masks, clears
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra0, rb0, ra1, rb1;
      ra0 = $urandom; rb0 = $urandom; ra1 = $urandom; rb1 = $urandom;
      if ($urandom % 10 == 0) begin ra0 = 32'hFFFF_FF80; rb0 = 32'hFFFF_8080; end
      step(($urandom % 4) != 0, $urandom % 2, 2'($urandom), 2'($urandom),
           2'($urandom), ra0, rb0, ra1, rb1, $urandom, $urandom,
           ($urandom % 16) == 0, "R2");
    end
    repeat (3) idle(1'b0);

    summary();
    $finish;
  end

endmodule